// File: doc/BRIEF.md
# Dead-Time Shifted Pulse Pair Generator

This block produces two positive pulses, one right after the other, from a single free-running up-counter. The first output is a plain compare output. It is high from the start of each counter period until the counter reaches its compare value. The second output is taken from its own compare reference, which is high from counter zero up to a second compare value. That reference then passes through a dead-time stage, which holds back only its leading edge. The compare value of the second output therefore sets where its pulse ends, and the dead-time sets where it starts. When the decoded dead-time equals the first compare value, the first pulse falls and the second pulse rises on the same clock edge.

The dead-time is set by an 8-bit code that decodes non-linearly, so short delays have single-clock resolution and long delays are coarser. A complementary dead-time path is computed from the inverted reference but is not driven out. Period, compare and dead-time inputs are held in shadow registers that load only at a counter wrap, so the values can be written at any time without disturbing the period in progress.

Top module: `dtpulse_pair`

## Requirements
- R1: On each cycle with `en_i` high the counter advances by one, and from the active period value it wraps to 0. With `en_i` low the counter and all outputs hold their values.
- R2: `upd_o` is high for exactly the one clock that follows each wrap. In that clock the counter is 0.
- R3: `pulse_a_o` is high exactly while counter < active compare-A value. It is never delayed.
- R4: With active compare-B ≤ active period, `pulse_b_o` is high exactly while decoded dead-time ≤ counter < active compare-B. Compare-B therefore sets the trailing edge, not the pulse length.
- R5: When decoded dead-time ≥ active compare-B, `pulse_b_o` stays low for the whole period.
- R6: The 8-bit dead-time code decodes to clocks as follows. Bit 7 = 0 gives bits[6:0]. Bits[7:6] = 10 gives (64 + bits[5:0]) × 2. Bits[7:5] = 110 gives (32 + bits[4:0]) × 8. Bits[7:5] = 111 gives (32 + bits[4:0]) × 16.
- R7: When the decoded dead-time equals a non-zero compare-A, `pulse_b_o` rises on the same clock edge on which `pulse_a_o` falls.
- R8: The period, compare and dead-time inputs take effect only at the next wrap. A change made mid-period leaves the current period unchanged.
- R9: During and after reset all outputs are low, the counter is 0 and all shadow values are 0. The first enabled cycle is therefore a wrap, and it loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Counter enable; low freezes the block |
| period_i | input | CNT_W | Last count value of a period (period length is value + 1) |
| cmp_a_i | input | CNT_W | Compare value where output A ends |
| cmp_b_i | input | CNT_W | Compare value where output B ends |
| dt_code_i | input | DT_CODE_W | Non-linear dead-time code for output B |
| pulse_a_o | output | 1 | First pulse |
| pulse_b_o | output | 1 | Second pulse, leading edge delayed by dead-time |
| upd_o | output | 1 | One-clock strobe after each wrap |

## Verification
The assertions on output B assume that the active compare-B value never exceeds the active period. Under that condition the reference falls before every wrap and rises again at counter zero, so each period restarts the dead-time. The stimulus writes every configuration as one consistent set in a single cycle, so the shadow registers never hold a mixed set. Every set it applies keeps compare-B at or below the period, including the sets written mid-period and the sets applied while the enable toggles at random.

// File: rtl/dtpulse_pkg.sv
`timescale 1ns/1ps
package dtpulse_pkg;

   // Width of the dead-time code that the decoder understands.
   localparam int DT_CODE_BITS = 8;

   // Largest decoded delay is (32 + 31) * 16 = 1008, which needs 10 bits.
   localparam int DT_MIN_OUT_W = 10;

   // Decoded range of the dead-time code, selected by its leading bits.
   typedef enum logic [1:0] {
      DT_LIN = 2'd0,   // single-clock steps
      DT_X2  = 2'd1,   // two-clock steps
      DT_X8  = 2'd2,   // eight-clock steps
      DT_X16 = 2'd3    // sixteen-clock steps
   } dt_range_e;

endpackage

// File: rtl/dtpulse_dtdecode.sv
`timescale 1ns/1ps
module dtpulse_dtdecode
   import dtpulse_pkg::*;
#(
   parameter int OUT_W = 16
) (
   input  logic [DT_CODE_BITS-1:0] code_i,
   output logic [OUT_W-1:0]        cycles_o
);

   if (OUT_W < DT_MIN_OUT_W) begin : g_bad_width
      $error("dtpulse_dtdecode: OUT_W too small for the largest delay");
   end

   dt_range_e range;

   always_comb begin
      if (!code_i[7])      range = DT_LIN;
      else if (!code_i[6]) range = DT_X2;
      else if (!code_i[5]) range = DT_X8;
      else                 range = DT_X16;
   end

   // An added leading one forms the 64 + x and 32 + x offsets.
   always_comb begin
      unique case (range)
         DT_LIN:  cycles_o = OUT_W'(code_i[6:0]);
         DT_X2:   cycles_o = OUT_W'({1'b1, code_i[5:0]}) << 1;
         DT_X8:   cycles_o = OUT_W'({1'b1, code_i[4:0]}) << 3;
         default: cycles_o = OUT_W'({1'b1, code_i[4:0]}) << 4;
      endcase
   end

   always_comb begin
      a_r6_range_bound : assert (cycles_o <= OUT_W'(1008))
         else $error("R6: decoded delay out of range");
   end

endmodule

// File: rtl/dtpulse_timebase.sv
`timescale 1ns/1ps
module dtpulse_timebase #(
   parameter int CNT_W  = 16,
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  cmp_a_i,
   input  logic [CNT_W-1:0]  cmp_b_i,
   input  logic [CODE_W-1:0] dt_code_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  cmp_a_o,
   output logic [CNT_W-1:0]  cmp_b_o,
   output logic [CODE_W-1:0] dt_code_o,
   output logic              upd_o
);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  per_q;
   logic [CNT_W-1:0]  cma_q;
   logic [CNT_W-1:0]  cmb_q;
   logic [CODE_W-1:0] code_q;
   logic              upd_q;
   logic              wrap;

   assign wrap = en_i && (cnt_q == per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= '0;
         cma_q  <= '0;
         cmb_q  <= '0;
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= wrap;
         if (wrap) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            cma_q  <= cmp_a_i;
            cmb_q  <= cmp_b_i;
            code_q <= dt_code_i;
         end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign cmp_a_o   = cma_q;
   assign cmp_b_o   = cmb_q;
   assign dt_code_o = code_q;
   assign upd_o     = upd_q;

   a_r1_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= per_q)
      else $error("R1: counter beyond period");

   a_r1_stall : assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(cnt_q))
      else $error("R1: counter moved while disabled");

   a_r2_wrap_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cnt_q == per_q) |=> (cnt_q == '0 && upd_q))
      else $error("R2: wrap without strobe");

   a_r2_strobe_at_zero : assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> cnt_q == '0)
      else $error("R2: strobe off counter zero");

   a_r8_shadow_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(en_i && cnt_q == per_q) |=>
         ($stable(per_q) && $stable(cma_q) && $stable(cmb_q) && $stable(code_q)))
      else $error("R8: shadow changed outside a wrap");

endmodule

// File: rtl/dtpulse_deadtime.sv
`timescale 1ns/1ps
module dtpulse_deadtime #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             ref_i,
   input  logic [CNT_W-1:0] dt_i,
   output logic             out_o
);

   logic             ref_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] rem_eff;
   logic             rise;

   assign rise    = ref_i & ~ref_q;
   assign rem_eff = rise ? dt_i : rem_q;
   assign out_o   = ref_i & (rem_eff == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         rem_q <= '0;
      end else if (en_i) begin
         ref_q <= ref_i;
         rem_q <= (rem_eff == '0) ? '0 : rem_eff - 1'b1;
      end
   end

   a_r4_lead_held : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && rise && dt_i > CNT_W'(1)) |=> !out_o)
      else $error("R4: leading edge not delayed");

   a_r4_trail_follows : assert property (@(posedge clk) disable iff (!rst_n)
      !ref_i |-> !out_o)
      else $error("R4: output outlived its reference");

endmodule

// File: rtl/dtpulse_pair.sv
`timescale 1ns/1ps
module dtpulse_pair
   import dtpulse_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DT_CODE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic [CNT_W-1:0]     period_i,
   input  logic [CNT_W-1:0]     cmp_a_i,
   input  logic [CNT_W-1:0]     cmp_b_i,
   input  logic [DT_CODE_W-1:0] dt_code_i,
   output logic                 pulse_a_o,
   output logic                 pulse_b_o,
   output logic                 upd_o
);

   localparam int NUM_POL = 2;   // index 0: true path, index 1: complementary

   if (DT_CODE_W != DT_CODE_BITS) begin : g_bad_code
      $error("dtpulse_pair: dead-time code must be 8 bits");
   end
   if (CNT_W < DT_MIN_OUT_W) begin : g_bad_cnt
      $error("dtpulse_pair: counter narrower than the longest dead-time");
   end

   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     cma;
   logic [CNT_W-1:0]     cmb;
   logic [DT_CODE_W-1:0] code;
   logic [CNT_W-1:0]     dt_cyc;
   logic                 ref_b;
   logic [NUM_POL-1:0]   pol_ref;
   logic [NUM_POL-1:0]   pol_out;
   logic                 comp_b;

   dtpulse_timebase #(.CNT_W(CNT_W), .CODE_W(DT_CODE_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .period_i  (period_i),
      .cmp_a_i   (cmp_a_i),
      .cmp_b_i   (cmp_b_i),
      .dt_code_i (dt_code_i),
      .cnt_o     (cnt),
      .cmp_a_o   (cma),
      .cmp_b_o   (cmb),
      .dt_code_o (code),
      .upd_o     (upd_o)
   );

   dtpulse_dtdecode #(.OUT_W(CNT_W)) u_dec (
      .code_i   (code),
      .cycles_o (dt_cyc)
   );

   assign pulse_a_o = (cnt < cma);
   assign ref_b     = (cnt < cmb);
   assign pol_ref   = {~ref_b, ref_b};

   for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
      dtpulse_deadtime #(.CNT_W(CNT_W)) u_dt (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (en_i),
         .ref_i (pol_ref[g]),
         .dt_i  (dt_cyc),
         .out_o (pol_out[g])
      );
   end

   assign pulse_b_o = pol_out[0];
   assign comp_b    = pol_out[1];

   a_r3_a_fall_point : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_a_o) |-> (cnt == cma || cnt == '0))
      else $error("R3: output A fell off its compare point");

   a_r4_b_rise_point : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_b_o) |-> cnt == dt_cyc)
      else $error("R4: output B rose off the dead-time point");

   a_r4_comp_gap : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pulse_b_o) && dt_cyc != '0) |-> !comp_b)
      else $error("R4: complementary path lacks dead-time");

   a_r5_b_suppressed : assert property (@(posedge clk) disable iff (!rst_n)
      (dt_cyc >= cmb) |-> !pulse_b_o)
      else $error("R5: output B high with dead-time past compare");

   a_r7_edges_meet : assert property (@(posedge clk) disable iff (!rst_n)
      (dt_cyc == cma && cma != '0 && $rose(pulse_b_o)) |-> $fell(pulse_a_o))
      else $error("R7: edges not coincident");

endmodule

// File: tb/dtpulse_pair_test.sv
`timescale 1ns/1ps
module dtpulse_pair_test;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_i = 1'b0;
   logic [CW-1:0] period_i = '0;
   logic [CW-1:0] cmp_a_i = '0;
   logic [CW-1:0] cmp_b_i = '0;
   logic [7:0]    dt_code_i = '0;
   logic          pulse_a_o, pulse_b_o, upd_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   string b_req = "R4";

   always #4 clk = ~clk;   // 125 MHz

   dtpulse_pair #(.CNT_W(CW), .DT_CODE_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i),
      .period_i(period_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
      .dt_code_i(dt_code_i),
      .pulse_a_o(pulse_a_o), .pulse_b_o(pulse_b_o), .upd_o(upd_o)
   );

   // Dead-time code mapping as given in R6.
   function automatic int decode_dt(bit [7:0] c);
      if (!c[7]) return int'(c[6:0]);
      if (!c[6]) return (64 + int'(c[5:0])) * 2;
      if (!c[5]) return (32 + int'(c[4:0])) * 8;
      return (32 + int'(c[4:0])) * 16;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model.
   int m_cnt, m_per, m_ca, m_cb, m_dt;
   bit m_upd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_per <= 0; m_ca <= 0; m_cb <= 0; m_dt <= 0; m_upd <= 0;
      end else begin
         m_upd <= 0;
         if (en_i) begin
            if (m_cnt == m_per) begin
               m_cnt <= 0;
               m_per <= int'(period_i);
               m_ca  <= int'(cmp_a_i);
               m_cb  <= int'(cmp_b_i);
               m_dt  <= decode_dt(dt_code_i);
               m_upd <= 1;
            end else begin
               m_cnt <= m_cnt + 1;
            end
         end
      end
   end

   // Per-clock comparison, away from the active edge.
   bit prev_a = 0, prev_b = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_a, exp_b;
         exp_a = (m_cnt < m_ca);
         exp_b = (m_cnt >= m_dt) && (m_cnt < m_cb);
         check(pulse_a_o == exp_a, "R3 (count per R1)", pulse_a_o, exp_a);
         if (m_dt >= m_cb)
            check(pulse_b_o == 1'b0, "R5", pulse_b_o, 0);
         else
            check(pulse_b_o == exp_b, b_req, pulse_b_o, exp_b);
         check(upd_o == m_upd, "R2", upd_o, m_upd);
         if (m_dt == m_ca && m_ca != 0 && !prev_b && pulse_b_o)
            check(prev_a && !pulse_a_o, "R7", pulse_a_o, 0);
         prev_a = pulse_a_o;
         prev_b = pulse_b_o;
      end
   end

   task automatic set_cfg(int per, int ca, int cb, bit [7:0] code);
      period_i  = CW'(per);
      cmp_a_i   = CW'(ca);
      cmp_b_i   = CW'(cb);
      dt_code_i = code;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R9: reset state
      run(3);
      check(pulse_a_o == 0, "R9", pulse_a_o, 0);
      check(pulse_b_o == 0, "R9", pulse_b_o, 0);
      check(upd_o == 0, "R9", upd_o, 0);
      rst_n = 1'b1;
      run(3);
      check(pulse_a_o == 0 && pulse_b_o == 0, "R9", pulse_a_o | pulse_b_o, 0);

      // First enabled cycle wraps and loads (R9), aligned edges (R7).
      set_cfg(20, 4, 12, 8'd4);
      en_i = 1'b1;
      b_req = "R4";
      @(negedge clk);
      check(upd_o == 1, "R9", upd_o, 1);
      check(pulse_a_o == 1, "R9", pulse_a_o, 1);
      run(60);

      // Dead-time beyond compare-B (R5).
      set_cfg(20, 4, 12, 8'd20);
      run(50);
      // Zero dead-time, zero compare-A (R4).
      set_cfg(15, 0, 6, 8'd0);
      run(40);
      // Zero compare-B (R5).
      set_cfg(10, 3, 0, 8'd3);
      run(30);

      // Each decode range (R6).
      b_req = "R6";
      set_cfg(250, 134, 200, 8'h83);
      run(520);
      set_cfg(320, 264, 300, 8'hC1);
      run(660);
      set_cfg(600, 544, 560, 8'hE2);
      run(1220);
      set_cfg(140, 127, 135, 8'h7F);
      run(300);

      // Mid-period writes (R8).
      b_req = "R8";
      set_cfg(30, 5, 20, 8'd5);
      run(75);
      set_cfg(12, 2, 9, 8'd2);
      run(7);
      set_cfg(40, 9, 33, 8'd11);
      run(13);
      set_cfg(18, 6, 15, 8'd6);
      run(90);

      // Random enable stalls (R1).
      b_req = "R4 with stalls (R1)";
      set_cfg(25, 6, 18, 8'd6);
      for (int i = 0; i < 400; i++) begin
         en_i = ($urandom_range(0, 3) != 0);
         @(negedge clk);
      end
      en_i = 1'b1;
      run(20);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule